// File: doc/BRIEF.md
# Single-Port Memory FIFO with Access Arbitration

This block is a first-in first-out queue, clocked by one clock, whose entries sit in a memory with a single address port. Because the memory can perform only one access per clock, a writer and a reader that both want the memory in the same cycle cannot both be served. An arbiter picks one of them. The side that loses is told so through its own wait output and must present the request again.

The producer side sees a ready flag that is high while space remains. The consumer side sees an available flag that is high while at least one entry is stored. Read data comes out of a register. A one-cycle valid pulse marks each new word, and that pulse follows the cycle in which the read won the memory. When both sides compete, the arbiter alternates between them, so a steady stream on one side cannot starve the other.

Top module: `sp_fifo`

## Requirements
- R1: While reset is high, and in the first cycle after it, the queue is empty. `wr_ready` is 1, `rd_avail` is 0, `rd_valid` is 0 and `rd_data` is 0.
- R2: The memory carries out at most one access per cycle. When a write and a read are both eligible, exactly one of `wr_wait` and `rd_wait` is 1.
- R3: Words are read out in the order they were written. A read that wins the memory in cycle N gives `rd_valid` = 1 with the word on `rd_data` in cycle N+1. In every other cycle `rd_valid` is 0.
- R4: `wr_ready` is 0 exactly when DEPTH entries are stored. `rd_avail` is 1 exactly when at least one entry is stored.
- R5: A write presented while `wr_ready` is 0 is ignored. Nothing is stored, the entry count does not change, and `wr_wait` stays 0.
- R6: A read presented while `rd_avail` is 0 is ignored. The next cycle has `rd_valid` = 0, `rd_data` is unchanged, and `rd_wait` stays 0.
- R7: A request that is eligible and meets no competing eligible request is served in the same cycle, and its wait output is 0. A request that is not eligible never raises its wait output.
- R8: When both sides are eligible, the write wins the first such cycle after reset. After that, the winner alternates from one contended cycle to the next. Cycles with no contention do not change whose turn it is.
- R9: `rd_data` holds its value in every cycle that does not follow a granted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst | input | 1 | Synchronous active-high reset |
| wr_req | input | 1 | Producer asks to store `wr_data` this cycle |
| wr_data | input | WIDTH | Word to store |
| wr_ready | output | 1 | Space is available for a write |
| wr_wait | output | 1 | The eligible write lost arbitration this cycle |
| rd_req | input | 1 | Consumer asks to take the oldest word this cycle |
| rd_avail | output | 1 | At least one word is stored |
| rd_wait | output | 1 | The eligible read lost arbitration this cycle |
| rd_data | output | WIDTH | Registered read word |
| rd_valid | output | 1 | `rd_data` carries a new word this cycle |

## Verification
The assertions take the two request inputs to be known 0 or 1 at every clock edge, and they allow a request to be dropped or held after it loses or is refused. The checks on alternation compare only back-to-back contended cycles, so they assume nothing about how often the sides compete. The stimulus changes requests and data only on the falling edge. It drives the queue into full and empty and presents requests there, and it mixes single-sided and contended cycles at every fill level. No input ever goes unknown after reset.

// File: rtl/sp_fifo_pkg.sv
package sp_fifo_pkg;

  typedef enum logic [1:0] {
    MEM_IDLE  = 2'd0,
    MEM_WRITE = 2'd1,
    MEM_READ  = 2'd2
  } mem_op_e;

endpackage

// File: rtl/sp_fifo_ptrs.sv
module sp_fifo_ptrs #(
  parameter int DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         push,
  input  logic                         pop,
  output logic [$clog2(DEPTH)-1:0]     waddr,
  output logic [$clog2(DEPTH)-1:0]     raddr,
  output logic                         full,
  output logic                         empty
);

  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic [PW-1:0] wptr_q;
  logic [PW-1:0] rptr_q;

  // Pointers carry an extra wrap bit so full and empty can be told apart
  always_ff @(posedge clk) begin
    if (rst) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      if (push) wptr_q <= wptr_q + PW'(1);
      if (pop)  rptr_q <= rptr_q + PW'(1);
    end
  end

  assign waddr = wptr_q[AW-1:0];
  assign raddr = rptr_q[AW-1:0];
  assign empty = (wptr_q == rptr_q);
  assign full  = (wptr_q[AW-1:0] == rptr_q[AW-1:0]) && (wptr_q[AW] != rptr_q[AW]);

endmodule

// File: rtl/sp_fifo_arb.sv
module sp_fifo_arb
  import sp_fifo_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    wr_elig,
  input  logic    rd_elig,
  output mem_op_e op,
  output logic    wr_wait,
  output logic    rd_wait
);

  logic read_turn_q;
  logic contend;

  assign contend = wr_elig && rd_elig;

  always_comb begin
    if (contend)      op = read_turn_q ? MEM_READ : MEM_WRITE;
    else if (wr_elig) op = MEM_WRITE;
    else if (rd_elig) op = MEM_READ;
    else              op = MEM_IDLE;
  end

  assign wr_wait = wr_elig && (op != MEM_WRITE);
  assign rd_wait = rd_elig && (op != MEM_READ);

  // Turn flips only on contended cycles, so the last loser wins next time
  always_ff @(posedge clk) begin
    if (rst)          read_turn_q <= 1'b0;
    else if (contend) read_turn_q <= ~read_turn_q;
  end

endmodule

// File: rtl/sp_fifo_mem.sv
module sp_fifo_mem
  import sp_fifo_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  mem_op_e                  op,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  input  logic [WIDTH-1:0]         wdata,
  output logic [WIDTH-1:0]         rdata,
  output logic                     rvalid
);

  localparam int AW = $clog2(DEPTH);

  logic [WIDTH-1:0] store [DEPTH];
  logic [AW-1:0]    addr;
  logic             wen;
  logic             ren;

  // One address port shared by both operations
  assign wen  = (op == MEM_WRITE);
  assign ren  = (op == MEM_READ);
  assign addr = wen ? waddr : raddr;

  always_ff @(posedge clk) begin
    if (wen) store[addr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= ren;
      if (ren) rdata <= store[addr];
    end
  end

endmodule

// File: rtl/sp_fifo.sv
module sp_fifo
  import sp_fifo_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_req,
  input  logic [WIDTH-1:0] wr_data,
  output logic             wr_ready,
  output logic             wr_wait,
  input  logic             rd_req,
  output logic             rd_avail,
  output logic             rd_wait,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_valid
);

  localparam int AW = $clog2(DEPTH);

  logic          full;
  logic          empty;
  logic [AW-1:0] waddr;
  logic [AW-1:0] raddr;
  mem_op_e       op;
  logic          gnt_wr;
  logic          gnt_rd;

  assign wr_ready = !full;
  assign rd_avail = !empty;
  assign gnt_wr   = (op == MEM_WRITE);
  assign gnt_rd   = (op == MEM_READ);

  sp_fifo_arb u_arb (
    .clk     (clk),
    .rst     (rst),
    .wr_elig (wr_req && !full),
    .rd_elig (rd_req && !empty),
    .op      (op),
    .wr_wait (wr_wait),
    .rd_wait (rd_wait)
  );

  sp_fifo_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk   (clk),
    .rst   (rst),
    .push  (gnt_wr),
    .pop   (gnt_rd),
    .waddr (waddr),
    .raddr (raddr),
    .full  (full),
    .empty (empty)
  );

  sp_fifo_mem #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_mem (
    .clk    (clk),
    .rst    (rst),
    .op     (op),
    .waddr  (waddr),
    .raddr  (raddr),
    .wdata  (wr_data),
    .rdata  (rd_data),
    .rvalid (rd_valid)
  );

endmodule

// File: rtl/sp_fifo_chk.sv
module sp_fifo_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_req,
  input logic             rd_req,
  input logic             wr_ready,
  input logic             rd_avail,
  input logic             wr_wait,
  input logic             rd_wait,
  input logic [WIDTH-1:0] rd_data,
  input logic             rd_valid,
  input logic             gnt_wr,
  input logic             gnt_rd
);

  logic contended;
  assign contended = wr_req && wr_ready && rd_req && rd_avail;

  a_r2_one_access: assert property (@(posedge clk) disable iff (rst)
    !(gnt_wr && gnt_rd));

  a_r2_one_waits: assert property (@(posedge clk) disable iff (rst)
    contended |-> (wr_wait != rd_wait));

  a_r3_valid_after_grant: assert property (@(posedge clk) disable iff (rst)
    gnt_rd |=> rd_valid);

  a_r3_no_stray_valid: assert property (@(posedge clk) disable iff (rst)
    !gnt_rd |=> !rd_valid);

  a_r5_no_write_when_full: assert property (@(posedge clk) disable iff (rst)
    !wr_ready |-> (!gnt_wr && !wr_wait));

  a_r6_no_read_when_empty: assert property (@(posedge clk) disable iff (rst)
    !rd_avail |-> (!gnt_rd && !rd_wait));

  a_r7_lone_write_served: assert property (@(posedge clk) disable iff (rst)
    (wr_req && wr_ready && !(rd_req && rd_avail)) |-> (gnt_wr && !wr_wait));

  a_r7_lone_read_served: assert property (@(posedge clk) disable iff (rst)
    (rd_req && rd_avail && !(wr_req && wr_ready)) |-> (gnt_rd && !rd_wait));

  a_r8_alternate: assert property (@(posedge clk) disable iff (rst)
    contended |=> (contended |-> (wr_wait != $past(wr_wait))));

  a_r9_hold_data: assert property (@(posedge clk) disable iff (rst)
    !rd_valid |-> $stable(rd_data));

endmodule

bind sp_fifo sp_fifo_chk #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .wr_req   (wr_req),
  .rd_req   (rd_req),
  .wr_ready (wr_ready),
  .rd_avail (rd_avail),
  .wr_wait  (wr_wait),
  .rd_wait  (rd_wait),
  .rd_data  (rd_data),
  .rd_valid (rd_valid),
  .gnt_wr   (gnt_wr),
  .gnt_rd   (gnt_rd)
);

// File: tb/test_sp_fifo.sv
`timescale 1ns/1ps
module test_sp_fifo;

  localparam int WIDTH = 8;
  localparam int DEPTH = 4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             wr_req = 1'b0;
  logic [WIDTH-1:0] wr_data = '0;
  logic             rd_req = 1'b0;
  logic             wr_ready, wr_wait, rd_avail, rd_wait, rd_valid;
  logic [WIDTH-1:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Reference model state
  logic [WIDTH-1:0] q [DEPTH];
  int               head = 0;
  int               cnt = 0;
  bit               turn_rd = 0;
  logic [WIDTH-1:0] exp_data = '0;
  bit               exp_valid = 0;
  bit               prev_empty_rd = 0;
  logic [WIDTH-1:0] next_val = 8'h11;

  always #2 clk = ~clk;

  sp_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) i_sp_fifo (
    .clk(clk), .rst(rst), .wr_req(wr_req), .wr_data(wr_data),
    .wr_ready(wr_ready), .wr_wait(wr_wait), .rd_req(rd_req),
    .rd_avail(rd_avail), .rd_wait(rd_wait), .rd_data(rd_data),
    .rd_valid(rd_valid)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Called on a falling edge; returns on the next falling edge
  task automatic step(input bit w, input bit r);
    bit we, re, gw, gr, con;
    if (prev_empty_rd) begin
      check("R6 read on empty gives no valid", rd_valid, 0);
      check("R6 read on empty keeps rd_data", rd_data, exp_data);
    end else begin
      check("R3 rd_valid timing", rd_valid, exp_valid);
      if (exp_valid) check("R3 read order", rd_data, exp_data);
      else           check("R9 rd_data held", rd_data, exp_data);
    end
    check("R4 wr_ready", wr_ready, (cnt < DEPTH));
    check("R4 rd_avail", rd_avail, (cnt > 0));
    wr_req  = w;
    rd_req  = r;
    wr_data = next_val;
    #1;
    we  = w && (cnt < DEPTH);
    re  = r && (cnt > 0);
    con = we && re;
    gw  = con ? !turn_rd : we;
    gr  = con ? turn_rd  : re;
    if (con) begin
      check("R2 one side waits", wr_wait ^ rd_wait, 1);
      check("R8 write wait by turn", wr_wait, turn_rd);
      check("R8 read wait by turn", rd_wait, !turn_rd);
      turn_rd = !turn_rd;
    end else begin
      if (w && cnt == DEPTH) check("R5 write on full no wait", wr_wait, 0);
      else                   check("R7 write wait uncontested", wr_wait, 0);
      if (r && cnt == 0)     check("R6 read on empty no wait", rd_wait, 0);
      else                   check("R7 read wait uncontested", rd_wait, 0);
    end
    prev_empty_rd = r && (cnt == 0);
    exp_valid = gr;
    if (gr) begin
      exp_data = q[head];
      head = (head + 1) % DEPTH;
      cnt--;
    end
    if (gw) begin
      q[(head + cnt) % DEPTH] = next_val;
      cnt++;
      next_val = next_val + 8'd7;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 wr_ready in reset", wr_ready, 1);
    check("R1 rd_avail in reset", rd_avail, 0);
    check("R1 rd_valid in reset", rd_valid, 0);
    check("R1 rd_data in reset", rd_data, 0);
    rst = 1'b0;
    // Fill past full: extra writes must be ignored (R5)
    for (int i = 0; i < DEPTH + 3; i++) step(1, 0);
    // Drain past empty: extra reads must be ignored (R6)
    for (int i = 0; i < DEPTH + 3; i++) step(0, 1);
    // Contention from a partly filled queue (R8 start: write first)
    step(1, 0);
    for (int i = 0; i < 6; i++) step(1, 1);
    // Mixed sweep over all request pairs at every fill level
    for (int i = 0; i < 600; i++) begin
      int h;
      int ph;
      h  = (i * 37 + (i >> 2) * 11) % 7;
      ph = (i / 50) % 3;
      if (ph == 0)      step(h < 5, (h % 3) == 0);
      else if (ph == 1) step(h < 2, (h % 4) != 0);
      else              step((i % 4) < 2, (i % 4) != 1);
    end
    // Contended at full and empty borders
    for (int i = 0; i < DEPTH + 2; i++) step(1, 0);
    for (int i = 0; i < 8; i++) step(1, 1);
    for (int i = 0; i < DEPTH + 4; i++) step(0, 1);
    step(1, 1);
    step(0, 0);
    step(0, 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule